// File: doc/BRIEF.md
# Ultrasonic Burst Cycle Sequencer

This block is the time base for a repeating ultrasonic measurement. One free-running counter splits time into fixed cycles of 37500 counts, which is 1.25 ms at a 30 MHz count clock. At the start of each cycle the block sends a short transmit burst. The burst is a counted train of toggles on one output. The toggle times come from a compare value that moves forward by one half-period after each match.

The same counter drives three markers in the style of PWM mode 2. Each marker is low from the cycle start and goes high when the count reaches its own threshold. The markers tell the surrounding blocks when to gate timestamp capture, when to enable the receiver and when detection has ended. A one-clock cycle-start pulse clears the downstream timestamp counter. Two one-clock events mark the opening and closing of the capture window.

Top module: `burst_sequencer`

## Requirements
- R1: While reset is asserted, the burst output is high, all three markers and both window events are low, and the cycle-start output is high, because the counter rests at count 0.
- R2: The cycle-start output is high for exactly one clock every CYCLE_LEN (default 37500) clocks. The position p within a cycle is counted from 0 at that clock.
- R3: Within the burst, the burst output changes level exactly at positions p = HALF_STEP*j for j = 1 to NUM_HALVES (defaults 375 and 16). It holds its level between those positions.
- R4: The burst output is high at the start of every cycle and goes low at the first toggle (p = HALF_STEP).
- R5: After toggle number NUM_HALVES (p = 6000 by default), the burst output stays high until the next cycle start. The toggle index restarts at every cycle start.
- R6: The capture-gate marker is low for p < 3750 and high for p >= 3750.
- R7: The receiver-enable marker is low for p < 9000 and high for p >= 9000.
- R8: The end-of-detection marker is low for p < 33000 and high for p >= 33000.
- R9: The window-open output is high for one clock only, at p = 3750, the rising edge of the capture-gate marker. The window-close output is high for one clock only, at p = 33000, the rising edge of the end-of-detection marker.
- R10: In the clock where the cycle-start output is high, all three markers are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_o | output | 1 | Transmit burst, idles high |
| gate_o | output | 1 | Capture-gate marker |
| rx_en_o | output | 1 | Receiver-enable marker |
| det_end_o | output | 1 | End-of-detection marker |
| cyc_start_o | output | 1 | One-clock pulse at count 0; clears the downstream timestamp counter |
| win_open_o | output | 1 | One-clock window-open event |
| win_close_o | output | 1 | One-clock window-close event |

## Verification
A wrong cycle count or a missed wrap shows up at once: cycle-start, the markers and the window events all move to the wrong clock, and the first cycle boundary exposes the error. A compare value or toggle index that is off by one step shows up on the burst output at the next toggle position, at most 375 clocks later. If the index fails to restart, toggles are missing in the second cycle, so the bench compares every output on every clock across three complete cycles.

// File: rtl/burst_sequencer.sv
module burst_sequencer #(
  parameter int CYCLE_LEN  = 37500,
  parameter int HALF_STEP  = 375,
  parameter int NUM_HALVES = 16,
  parameter int GATE_AT    = 3750,
  parameter int RX_AT      = 9000,
  parameter int END_AT     = 33000
) (
  input  logic clk,
  input  logic rst_n,
  output logic burst_o,
  output logic gate_o,
  output logic rx_en_o,
  output logic det_end_o,
  output logic cyc_start_o,
  output logic win_open_o,
  output logic win_close_o
);
  localparam int CW   = $clog2(CYCLE_LEN + HALF_STEP * (NUM_HALVES + 1));
  localparam int IW   = $clog2(NUM_HALVES + 1);
  localparam int LAST = CYCLE_LEN - 1;

  logic [CW-1:0] cnt, nxt, cmp;
  logic [IW-1:0] idx;
  logic          burst_q;

  assign nxt = (cnt == CW'(LAST)) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp     <= CW'(HALF_STEP);
      idx     <= '0;
      burst_q <= 1'b1;
    end else begin
      cnt <= nxt;
      if (nxt == '0) begin
        cmp <= CW'(HALF_STEP);
        idx <= '0;
      end else if (idx < IW'(NUM_HALVES) && nxt == cmp) begin
        burst_q <= ~burst_q;
        cmp     <= cmp + CW'(HALF_STEP);
        idx     <= idx + 1'b1;
      end
    end
  end

  assign burst_o     = burst_q;
  assign cyc_start_o = (cnt == '0);
  assign gate_o      = (cnt >= CW'(GATE_AT));
  assign rx_en_o     = (cnt >= CW'(RX_AT));
  assign det_end_o   = (cnt >= CW'(END_AT));
  assign win_open_o  = (cnt == CW'(GATE_AT));
  assign win_close_o = (cnt == CW'(END_AT));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(CYCLE_LEN));
  p_wrap_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(LAST)) |=> cyc_start_o);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_o |-> burst_o);
  p_toggle_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(NUM_HALVES));
  p_burst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IW'(NUM_HALVES) && cnt != CW'(LAST)) |=> $stable(burst_o));
  p_open_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_open_o |-> $rose(gate_o));
  p_close_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_close_o |-> $rose(det_end_o));
  p_markers_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_o |-> (!gate_o && !rx_en_o && !det_end_o));
endmodule

// File: tb/tb_burst_sequencer.sv
module tb_burst_sequencer;
  localparam int L = 37500;
  logic clk = 1'b0, rst_n = 1'b0;
  logic burst_o, gate_o, rx_en_o, det_end_o, cyc_start_o, win_open_o, win_close_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  burst_sequencer dut (.clk(clk), .rst_n(rst_n), .burst_o(burst_o), .gate_o(gate_o),
    .rx_en_o(rx_en_o), .det_end_o(det_end_o), .cyc_start_o(cyc_start_o),
    .win_open_o(win_open_o), .win_close_o(win_close_o));

  always #5 clk = ~clk;

  task automatic chk(input string req, input string name, input int p,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors <= 30)
        $display("FAIL %s %s at p=%0d actual %b expected %b", req, name, p, act, exp);
    end
  endtask

  initial begin
    int p;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "burst", 0, burst_o, 1'b1);
    chk("R1", "gate", 0, gate_o, 1'b0);
    chk("R1", "rx_en", 0, rx_en_o, 1'b0);
    chk("R1", "det_end", 0, det_end_o, 1'b0);
    chk("R1", "cyc_start", 0, cyc_start_o, 1'b1);
    chk("R1", "win_open", 0, win_open_o, 1'b0);
    chk("R1", "win_close", 0, win_close_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    p = 0;
    for (int n = 0; n < 3 * L + 20; n++) begin
      int tg;
      logic eb;
      string rb;
      #1;
      tg = p / 375;
      if (tg > 16) tg = 16;
      eb = (tg % 2 == 0);
      rb = (p < 375) ? "R4" : (p >= 6000) ? "R5" : "R3";
      chk(rb, "burst", p, burst_o, eb);
      chk("R6", "gate", p, gate_o, p >= 3750);
      chk("R7", "rx_en", p, rx_en_o, p >= 9000);
      chk("R8", "det_end", p, det_end_o, p >= 33000);
      chk("R2", "cyc_start", p, cyc_start_o, p == 0);
      chk("R9", "win_open", p, win_open_o, p == 3750);
      chk("R9", "win_close", p, win_close_o, p == 33000);
      if (p == 0) chk("R10", "markers_low", p, gate_o | rx_en_o | det_end_o, 1'b0);
      p = (p + 1) % L;
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(10 * 190000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule